// File: doc/BRIEF.md
# Batched Sector Erase Sequencer

This block gathers sector erase requests for a flash array into one batch and then runs that batch as a single erase. A command decoder upstream sends it one-cycle strobes. The first sector confirm opens an acceptance window that lasts a set number of cycles. Each further confirm that arrives while the window is open adds its sector to the batch and starts the window again. When the window expires, the block starts the erase engine, raises the window-closed status bit, and holds its busy flag until the engine reports completion.

The erase runs in two phases. The first phase pre-programs the selected sectors to all zeros. The second phase erases them to all ones. The engine pulses done at the end of each phase. While the erase is running, software can suspend it to read other sectors and can then resume it. A read probe on any sector that is part of the pending batch returns "in progress" instead of array data. The batch bitmap is cleared on reset, on abort and on completion.

Top module: `sector_erase_batcher`

## Requirements
- R1: After reset, sector_map is 0, and busy, window_closed, engine_start, engine_pause, erase_phase and probe_pending are all 0.
- R2: When the block is idle, a confirm with an in-range sector index sets that sector's bit in sector_map, raises busy and opens the window. window_closed stays 0 while the window is open.
- R3: The window closes WINDOW_CYCLES clock edges after the last accepted confirm. Every in-range confirm that arrives while the window is open adds its bit and restarts the count.
- R4: When the window expires, window_closed becomes 1 and engine_start is high for exactly one cycle, with erase_phase at 0 (pre-program).
- R5: While the window is open, reset_cmd or other_cmd aborts the batch: busy drops and sector_map clears. suspend_cmd and resume_cmd have no effect during the window.
- R6: While the erase runs, confirm_vld, other_cmd and resume_cmd have no effect on the state, the status or sector_map.
- R7: suspend_cmd during the erase raises engine_pause while busy and window_closed stay 1. engine_done is ignored while the erase is suspended. resume_cmd clears engine_pause.
- R8: The first engine_done while the erase is running moves erase_phase from 0 (pre-program) to 1 (erase). The second engine_done ends the erase, with busy, window_closed, erase_phase and sector_map all returning to 0.
- R9: probe_pending is 1 exactly when busy is 1 and the bit of probe_sector in sector_map is set.
- R10: reset_cmd while the erase is running or suspended returns the block to idle and clears sector_map.
- R11: A confirm whose sector index is NUM_SECTORS or greater is ignored: no bit is set and no window is opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| confirm_vld | input | 1 | Sector erase confirm strobe |
| confirm_sector | input | SECT_W | Sector index that goes with the confirm |
| suspend_cmd | input | 1 | Erase suspend strobe |
| resume_cmd | input | 1 | Erase resume strobe |
| reset_cmd | input | 1 | Reset command strobe |
| other_cmd | input | 1 | Strobe for any other decoded command |
| engine_done | input | 1 | Erase engine has finished the current phase |
| probe_sector | input | SECT_W | Sector being read |
| sector_map | output | NUM_SECTORS | Bitmap of the sectors in the batch |
| window_closed | output | 1 | 0 while idle or while the window is open; 1 once the erase has begun |
| busy | output | 1 | A batch is being collected or erased |
| engine_start | output | 1 | One-cycle start pulse to the erase engine |
| engine_pause | output | 1 | Erase engine must hold |
| erase_phase | output | 1 | 0 = pre-program, 1 = erase |
| probe_pending | output | 1 | The probed sector is in the pending batch |

## Verification
The assertions assume that the command strobes are one cycle wide and mutually exclusive. They also assume that engine_done comes only from an engine that has been started and is not paused. The block itself still ignores engine_done at any other time. The stimulus raises at most one strobe per cycle and drops it at the next falling edge. It issues engine_done only after the erase has started, and once during a suspend to show that done is ignored there.

// File: rtl/seb_pkg.sv
package seb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WINDOW,
      ST_ERASE,
      ST_SUSPEND
   } seb_state_e;

   typedef enum logic {
      PH_PREPROG,
      PH_ERASE
   } seb_phase_e;

   typedef struct packed {
      logic confirm;
      logic suspend;
      logic resume;
      logic reset;
      logic other;
      logic done;
   } seb_cmd_t;

endpackage

// File: rtl/seb_window_timer.sv
module seb_window_timer #(
   parameter int WINDOW_CYCLES = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic expired
);
   localparam int CW = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

   if (WINDOW_CYCLES < 2) begin : g_bad_window
      $error("seb_window_timer: WINDOW_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart || !run) begin
         cnt <= '0;
      end else if (cnt != LAST) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign expired = run && !restart && (cnt == LAST);

   // R3: each cycle of an open window moves the count on by one
   p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !restart && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

   // R3: a restart drops the count back to zero
   p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));

endmodule

// File: rtl/seb_sector_map.sv
module seb_sector_map #(
   parameter int NUM_SECTORS = 12,
   parameter int SECT_W      = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   set_en,
   input  logic [SECT_W-1:0]      set_idx,
   input  logic                   clr,
   input  logic [SECT_W-1:0]      rd_idx,
   output logic                   idx_ok,
   output logic                   rd_bit,
   output logic [NUM_SECTORS-1:0] map
);
   localparam bit FULL_RANGE = ((1 << SECT_W) == NUM_SECTORS);

   if (NUM_SECTORS < 1 || (1 << SECT_W) < NUM_SECTORS) begin : g_bad_width
      $error("seb_sector_map: SECT_W too narrow for NUM_SECTORS");
   end

   for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            map[i] <= 1'b0;
         end else if (set_en && set_idx == SECT_W'(i)) begin
            map[i] <= 1'b1;
         end
      end
   end

   if (FULL_RANGE) begin : g_full
      assign idx_ok = 1'b1;
      assign rd_bit = map[rd_idx];
   end else begin : g_partial
      assign idx_ok = (set_idx < SECT_W'(NUM_SECTORS));
      assign rd_bit = (rd_idx < SECT_W'(NUM_SECTORS)) ? map[rd_idx] : 1'b0;
   end

   // R5 / R8 / R10: clearing leaves an empty bitmap
   p_clear_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (map == '0));

   // R2: an accepted index is recorded
   p_set_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && idx_ok && !clr) |=> map[$past(set_idx)]);

   // R6: no set and no clear keeps the bitmap steady
   p_map_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !clr) |=> $stable(map));

endmodule

// File: rtl/seb_ctrl.sv
module seb_ctrl
   import seb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  seb_cmd_t   cmd,
   input  logic       idx_ok,
   input  logic       expired,
   output seb_state_e state,
   output seb_phase_e phase,
   output logic       set_en,
   output logic       clr,
   output logic       restart,
   output logic       run,
   output logic       start_q
);
   seb_state_e state_n;
   seb_phase_e phase_n;
   logic       start_n;
   logic       cfm_ok;

   assign cfm_ok = cmd.confirm && idx_ok;

   always_comb begin
      state_n = state;
      phase_n = phase;
      start_n = 1'b0;
      set_en  = 1'b0;
      clr     = 1'b0;
      restart = 1'b0;
      run     = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (cfm_ok && !cmd.reset && !cmd.other) begin
               state_n = ST_WINDOW;
               set_en  = 1'b1;
               restart = 1'b1;
            end
         end
         ST_WINDOW: begin
            run = 1'b1;
            if (cmd.reset || cmd.other) begin
               state_n = ST_IDLE;
               clr     = 1'b1;
            end else if (cfm_ok) begin
               set_en  = 1'b1;
               restart = 1'b1;
            end else if (expired) begin
               state_n = ST_ERASE;
               phase_n = PH_PREPROG;
               start_n = 1'b1;
            end
         end
         ST_ERASE: begin
            if (cmd.reset) begin
               state_n = ST_IDLE;
               phase_n = PH_PREPROG;
               clr     = 1'b1;
            end else if (cmd.done) begin
               if (phase == PH_PREPROG) begin
                  phase_n = PH_ERASE;
               end else begin
                  state_n = ST_IDLE;
                  phase_n = PH_PREPROG;
                  clr     = 1'b1;
               end
            end else if (cmd.suspend) begin
               state_n = ST_SUSPEND;
            end
         end
         ST_SUSPEND: begin
            if (cmd.reset) begin
               state_n = ST_IDLE;
               phase_n = PH_PREPROG;
               clr     = 1'b1;
            end else if (cmd.resume) begin
               state_n = ST_ERASE;
            end
         end
         default: begin
            state_n = ST_IDLE;
            clr     = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         phase   <= PH_PREPROG;
         start_q <= 1'b0;
      end else begin
         state   <= state_n;
         phase   <= phase_n;
         start_q <= start_n;
      end
   end

   // R5: abort from the window
   p_abort_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WINDOW && (cmd.reset || cmd.other)) |=> (state == ST_IDLE));

   // R6: only reset, done and suspend leave the running erase
   p_erase_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ERASE && !cmd.reset && !cmd.done && !cmd.suspend) |=> (state == ST_ERASE));

   // R7: a suspended erase waits for resume or reset
   p_suspend_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SUSPEND && !cmd.reset && !cmd.resume) |=> (state == ST_SUSPEND));

   // R4: the start pulse lasts one cycle
   p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);

   // R4: the start pulse comes only on the way from the window into the erase
   p_start_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> (state == ST_ERASE && $past(state) == ST_WINDOW));

   // R10: reset command during the erase returns to idle
   p_reset_erase_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_ERASE || state == ST_SUSPEND) && cmd.reset) |=> (state == ST_IDLE));

endmodule

// File: rtl/sector_erase_batcher.sv
module sector_erase_batcher
   import seb_pkg::*;
#(
   parameter int  NUM_SECTORS   = 12,
   parameter int  WINDOW_CYCLES = 32,
   localparam int SECT_W        = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   confirm_vld,
   input  logic [SECT_W-1:0]      confirm_sector,
   input  logic                   suspend_cmd,
   input  logic                   resume_cmd,
   input  logic                   reset_cmd,
   input  logic                   other_cmd,
   input  logic                   engine_done,
   input  logic [SECT_W-1:0]      probe_sector,
   output logic [NUM_SECTORS-1:0] sector_map,
   output logic                   window_closed,
   output logic                   busy,
   output logic                   engine_start,
   output logic                   engine_pause,
   output logic                   erase_phase,
   output logic                   probe_pending
);
   seb_cmd_t   cmd;
   seb_state_e state;
   seb_phase_e phase;
   logic       set_en, clr, restart, run, expired, idx_ok, rd_bit;

   assign cmd = '{confirm: confirm_vld, suspend: suspend_cmd, resume: resume_cmd,
                  reset: reset_cmd, other: other_cmd, done: engine_done};

   seb_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .idx_ok  (idx_ok),
      .expired (expired),
      .state   (state),
      .phase   (phase),
      .set_en  (set_en),
      .clr     (clr),
      .restart (restart),
      .run     (run),
      .start_q (engine_start)
   );

   seb_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (restart),
      .expired (expired)
   );

   seb_sector_map #(.NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W)) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (set_en),
      .set_idx (confirm_sector),
      .clr     (clr),
      .rd_idx  (probe_sector),
      .idx_ok  (idx_ok),
      .rd_bit  (rd_bit),
      .map     (sector_map)
   );

   assign busy          = (state != ST_IDLE);
   assign window_closed = (state == ST_ERASE) || (state == ST_SUSPEND);
   assign engine_pause  = (state == ST_SUSPEND);
   assign erase_phase   = (phase == PH_ERASE);
   assign probe_pending = busy && rd_bit;

   // R4: the closed-window status implies activity
   p_closed_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      window_closed |-> busy);

   // R7: the engine is paused only after the window has closed
   p_pause_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      engine_pause |-> window_closed);

   // R8: a finished batch leaves nothing behind
   p_idle_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sector_map == '0));

endmodule

// File: tb/sector_erase_batcher_bench.sv
module sector_erase_batcher_bench;
   localparam int N  = 12;
   localparam int W  = 32;
   localparam int SW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic confirm_vld = 1'b0, suspend_cmd = 1'b0, resume_cmd = 1'b0;
   logic reset_cmd = 1'b0, other_cmd = 1'b0, engine_done = 1'b0;
   logic [SW-1:0] confirm_sector = '0, probe_sector = '0;
   logic [N-1:0]  sector_map;
   logic window_closed, busy, engine_start, engine_pause, erase_phase, probe_pending;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   sector_erase_batcher #(.NUM_SECTORS(N), .WINDOW_CYCLES(W)) u_sector_erase_batcher (
      .clk(clk), .rst_n(rst_n), .confirm_vld(confirm_vld), .confirm_sector(confirm_sector),
      .suspend_cmd(suspend_cmd), .resume_cmd(resume_cmd), .reset_cmd(reset_cmd),
      .other_cmd(other_cmd), .engine_done(engine_done), .probe_sector(probe_sector),
      .sector_map(sector_map), .window_closed(window_closed), .busy(busy),
      .engine_start(engine_start), .engine_pause(engine_pause),
      .erase_phase(erase_phase), .probe_pending(probe_pending)
   );

   // op: 0 none, 1 confirm, 2 suspend, 3 resume, 4 reset cmd, 5 other, 6 done
   typedef struct packed {
      logic [2:0]  op;
      logic [3:0]  sec;
      logic [5:0]  wt;
      logic        busy;
      logic        closed;
      logic        pause;
      logic        phase;
      logic [11:0] map;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VECS [24] = '{
      '{3'd1, 4'd3,  6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 12'h008, 4'd2},  // R2 first confirm
      '{3'd1, 4'd5,  6'd10, 1'b1, 1'b0, 1'b0, 1'b0, 12'h028, 4'd3},  // R3 add and restart
      '{3'd2, 4'd0,  6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 12'h028, 4'd5},  // R5 suspend ignored
      '{3'd3, 4'd0,  6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 12'h028, 4'd5},  // R5 resume ignored
      '{3'd0, 4'd0,  6'd17, 1'b1, 1'b0, 1'b0, 1'b0, 12'h028, 4'd3},  // R3 still open
      '{3'd0, 4'd0,  6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 12'h028, 4'd3},  // R3 last open cycle
      '{3'd0, 4'd0,  6'd0,  1'b1, 1'b1, 1'b0, 1'b0, 12'h028, 4'd4},  // R4 window closed
      '{3'd1, 4'd7,  6'd0,  1'b1, 1'b1, 1'b0, 1'b0, 12'h028, 4'd6},  // R6 confirm ignored
      '{3'd5, 4'd0,  6'd0,  1'b1, 1'b1, 1'b0, 1'b0, 12'h028, 4'd6},  // R6 other ignored
      '{3'd3, 4'd0,  6'd0,  1'b1, 1'b1, 1'b0, 1'b0, 12'h028, 4'd6},  // R6 resume ignored
      '{3'd2, 4'd0,  6'd0,  1'b1, 1'b1, 1'b1, 1'b0, 12'h028, 4'd7},  // R7 suspend
      '{3'd6, 4'd0,  6'd0,  1'b1, 1'b1, 1'b1, 1'b0, 12'h028, 4'd7},  // R7 done ignored
      '{3'd3, 4'd0,  6'd0,  1'b1, 1'b1, 1'b0, 1'b0, 12'h028, 4'd7},  // R7 resume
      '{3'd6, 4'd0,  6'd0,  1'b1, 1'b1, 1'b0, 1'b1, 12'h028, 4'd8},  // R8 phase advance
      '{3'd6, 4'd0,  6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 4'd8},  // R8 completion
      '{3'd1, 4'd13, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 4'd11}, // R11 out of range
      '{3'd1, 4'd11, 6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 12'h800, 4'd2},  // R2 top sector
      '{3'd5, 4'd0,  6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 4'd5},  // R5 other aborts
      '{3'd1, 4'd0,  6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 12'h001, 4'd2},  // R2 sector zero
      '{3'd0, 4'd0,  6'd31, 1'b1, 1'b1, 1'b0, 1'b0, 12'h001, 4'd4},  // R4 expiry
      '{3'd2, 4'd0,  6'd0,  1'b1, 1'b1, 1'b1, 1'b0, 12'h001, 4'd7},  // R7 suspend
      '{3'd4, 4'd0,  6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 4'd10}, // R10 reset in suspend
      '{3'd1, 4'd2,  6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 12'h004, 4'd2},  // R2 new batch
      '{3'd4, 4'd0,  6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 4'd5}   // R5 reset aborts
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic [3:0] sec);
      confirm_sector = sec;
      confirm_vld = (op == 3'd1);
      suspend_cmd = (op == 3'd2);
      resume_cmd  = (op == 3'd3);
      reset_cmd   = (op == 3'd4);
      other_cmd   = (op == 3'd5);
      engine_done = (op == 3'd6);
      @(negedge clk);
      confirm_vld = 1'b0; suspend_cmd = 1'b0; resume_cmd = 1'b0;
      reset_cmd = 1'b0; other_cmd = 1'b0; engine_done = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 map", 32'(sector_map), 32'h0);
      chk("R1 busy", 32'(busy), 32'h0);
      chk("R1 closed", 32'(window_closed), 32'h0);
      chk("R1 start", 32'(engine_start), 32'h0);
      chk("R1 pause", 32'(engine_pause), 32'h0);
      chk("R1 phase", 32'(erase_phase), 32'h0);
      chk("R1 probe", 32'(probe_pending), 32'h0);

      for (int i = 0; i < 24; i++) begin
         drive(VECS[i].op, VECS[i].sec);
         repeat (int'(VECS[i].wt)) @(negedge clk);
         chk($sformatf("R%0d vec%0d busy", VECS[i].req, i), 32'(busy), 32'(VECS[i].busy));
         chk($sformatf("R%0d vec%0d closed", VECS[i].req, i), 32'(window_closed), 32'(VECS[i].closed));
         chk($sformatf("R%0d vec%0d pause", VECS[i].req, i), 32'(engine_pause), 32'(VECS[i].pause));
         chk($sformatf("R%0d vec%0d phase", VECS[i].req, i), 32'(erase_phase), 32'(VECS[i].phase));
         chk($sformatf("R%0d vec%0d map", VECS[i].req, i), 32'(sector_map), 32'(VECS[i].map));
      end

      // R4 start pulse timing and width
      drive(3'd1, 4'd1);
      chk("R4 no start while open", 32'(engine_start), 32'h0);
      repeat (W - 1) @(negedge clk);
      chk("R4 start not early", 32'(engine_start), 32'h0);
      chk("R3 open at last cycle", 32'(window_closed), 32'h0);
      @(negedge clk);
      chk("R4 start pulse", 32'(engine_start), 32'h1);
      chk("R4 closed at start", 32'(window_closed), 32'h1);
      chk("R4 phase preprog", 32'(erase_phase), 32'h0);
      // R9 probe
      probe_sector = 4'd1;
      #1 chk("R9 probe member", 32'(probe_pending), 32'h1);
      probe_sector = 4'd2;
      #1 chk("R9 probe non-member", 32'(probe_pending), 32'h0);
      @(negedge clk);
      chk("R4 start one cycle", 32'(engine_start), 32'h0);
      drive(3'd2, 4'd0);
      probe_sector = 4'd1;
      #1 chk("R9 probe while suspended", 32'(probe_pending), 32'h1);
      drive(3'd4, 4'd0);
      chk("R10 reset idle", 32'(busy), 32'h0);
      chk("R9 probe after reset", 32'(probe_pending), 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule